// File: doc/BRIEF.md
# Serial Debug Line-Reset and Mode Watcher

This block sits on the target side of a two-wire serial debug port. It runs on the debug clock and watches each sampled data bit that is marked valid. It counts consecutive ones to recognise a line reset. It also looks for the 16-bit selection pattern that moves the port out of its power-on JTAG mode and into serial-wire mode.

Three results come out of the block. The first is the current port mode. The second is a single-cycle pulse when a line reset is recognised. The third is a pending flag: it tells the packet layer that the host must read the identification register before any other access is accepted. The packet layer clears the flag by reporting a successful identification read. Packet decoding itself is outside this block.

Top module: `sdbg_line_watch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `swire_mode_o` = 0 (JTAG mode), `line_reset_o` = 0 and `id_pend_o` = 0.
- R2: `line_reset_o` is high for exactly one cycle. That cycle follows the clock edge that samples the 50th consecutive valid 1. Further valid ones give no new pulse until a valid 0 has been sampled.
- R3: A cycle with `valid_i` = 0 is ignored. Its `bit_i` neither extends nor breaks a run of ones, it takes no place in the select pattern, and it causes no output change.
- R4: `swire_mode_o` rises to 1 in the cycle after the edge that samples the last bit of the select pattern 0111100111100111. The bits are listed in sending order, so the leftmost bit is sent first. The switch happens only when the 16 valid pattern bits immediately follow at least 50 consecutive valid ones.
- R5: No mode switch happens when the pattern is preceded by only 49 valid ones. No mode switch happens when any single pattern bit differs.
- R6: Once `swire_mode_o` is 1, it stays 1 until `rst_n` is asserted.
- R7: `id_pend_o` rises in the same cycle as the `line_reset_o` pulse, but only when `swire_mode_o` was already 1. A line reset in JTAG mode leaves it at 0. This includes the run of ones that comes before the select pattern.
- R8: `id_pend_o` falls in the cycle after an edge that samples `id_ok_i` = 1. If a line reset in serial-wire mode is recognised on that same edge, the flag stays 1. `id_ok_i` has no effect while the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Sampled data-line bit |
| id_ok_i | input | 1 | Packet layer reports a successful identification read |
| swire_mode_o | output | 1 | 0 = JTAG mode, 1 = serial-wire mode |
| line_reset_o | output | 1 | One-cycle pulse on a recognised line reset |
| id_pend_o | output | 1 | Identification read required before other accesses |

## Verification
Every result is registered exactly once after the bit that causes it. The line-reset pulse, the mode change and the pending-flag update all appear in the cycle after the edge that samples the deciding bit or `id_ok_i`. The bench applies inputs on the falling edge and samples all three outputs one time unit after the next rising edge. At that point it compares them with a history-based model of the last 66 valid bits, and it does so for every bit it sends. The sweeps cover runs of 49 and 50 ones and every single-bit corruption of the pattern. They also cover invalid cycles placed inside runs and inside the pattern, and an identification acknowledgement that lands on the same edge as a line reset.

// File: rtl/sdbg_watch_pkg.sv
package sdbg_watch_pkg;

    // Port operating mode; JTAG is the power-on default
    typedef enum logic {
        MODE_JTAG  = 1'b0,
        MODE_SWIRE = 1'b1
    } port_mode_e;

    // Registered outputs of the watcher top
    typedef struct packed {
        port_mode_e mode;
        logic       lr_pulse;
        logic       id_pend;
    } watch_state_t;

    // Select pattern, first-sent bit in the MSB
    localparam logic [15:0] SELECT_PATTERN_DEFAULT = 16'h79E7;

endpackage

// File: rtl/sdbg_run_counter.sv
module sdbg_run_counter #(
    parameter int RUN_LEN = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic bit_i,
    output logic full_o,
    output logic hit_o
);
    localparam int              CNT_W   = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(RUN_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } run_state_t;

    run_state_t st_d, st_q;

    // Saturating run-of-ones counter; a valid zero clears it
    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            if (!bit_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = (st_q.cnt == CNT_MAX);
    assign hit_o  = valid_i && bit_i && (st_q.cnt == CNT_PRE);

endmodule

// File: rtl/sdbg_pattern_match.sv
module sdbg_pattern_match #(
    parameter int             PAT_W   = 16,
    parameter logic [PAT_W-1:0] PATTERN = 16'h79E7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic bit_i,
    input  logic armed_i,
    output logic match_o
);
    localparam int              POS_W    = $clog2(PAT_W + 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(PAT_W - 1);
    localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);

    typedef struct packed {
        logic [PAT_W-1:0] shreg;
        logic [POS_W-1:0] pos;
    } pat_state_t;

    pat_state_t       st_d, st_q;
    logic [PAT_W-1:0] shift_nx;

    // pos counts the valid bits received since the run of ones ended;
    // a compare is only meaningful when the 16th such bit arrives
    always_comb begin
        st_d     = st_q;
        shift_nx = {st_q.shreg[PAT_W-2:0], bit_i};
        if (valid_i) begin
            st_d.shreg = shift_nx;
            if (armed_i && !bit_i) begin
                st_d.pos = POS_ONE;
            end else if (st_q.pos == POS_LAST) begin
                st_d.pos = '0;
            end else if (st_q.pos != '0) begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = valid_i && (st_q.pos == POS_LAST) && (shift_nx == PATTERN);

endmodule

// File: rtl/sdbg_line_watch.sv
module sdbg_line_watch
    import sdbg_watch_pkg::*;
#(
    parameter int             RUN_LEN = 50,
    parameter int             PAT_W   = 16,
    parameter logic [PAT_W-1:0] PATTERN = SELECT_PATTERN_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic bit_i,
    input  logic id_ok_i,
    output logic swire_mode_o,
    output logic line_reset_o,
    output logic id_pend_o
);
    logic run_full;
    logic run_hit;
    logic pat_match;

    watch_state_t st_d, st_q;

    sdbg_run_counter #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .bit_i   (bit_i),
        .full_o  (run_full),
        .hit_o   (run_hit)
    );

    sdbg_pattern_match #(
        .PAT_W   (PAT_W),
        .PATTERN (PATTERN)
    ) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .bit_i   (bit_i),
        .armed_i (run_full),
        .match_o (pat_match)
    );

    always_comb begin
        st_d          = st_q;
        st_d.lr_pulse = run_hit;
        if (pat_match) begin
            st_d.mode = MODE_SWIRE;
        end
        // a fresh line reset in serial-wire mode outranks the acknowledge
        if (run_hit && (st_q.mode == MODE_SWIRE)) begin
            st_d.id_pend = 1'b1;
        end else if (id_ok_i) begin
            st_d.id_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_JTAG, lr_pulse: 1'b0, id_pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign swire_mode_o = (st_q.mode == MODE_SWIRE);
    assign line_reset_o = st_q.lr_pulse;
    assign id_pend_o    = st_q.id_pend;

endmodule

// File: rtl/sdbg_line_watch_chk.sv
module sdbg_line_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic valid_i,
    input logic bit_i,
    input logic id_ok_i,
    input logic swire_mode_o,
    input logic line_reset_o,
    input logic id_pend_o
);
    // R2: the pulse never lasts two cycles
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset_o |=> !line_reset_o);

    // R2: a pulse is always caused by a sampled valid one
    p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset_o |-> $past(valid_i && bit_i));

    // R3: an invalid cycle changes nothing visible
    p_invalid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!line_reset_o && $stable(swire_mode_o)));

    // R4: the last pattern bit is a valid one
    p_mode_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swire_mode_o) |-> $past(valid_i && bit_i));

    // R6: serial-wire mode is sticky
    p_mode_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swire_mode_o |=> swire_mode_o);

    // R7: pending flag only in serial-wire mode, raised with a line reset
    p_pend_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        id_pend_o |-> swire_mode_o);

    p_pend_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_pend_o) |-> line_reset_o);

    // R8: the flag only drops after an acknowledge
    p_pend_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_pend_o) |-> $past(id_ok_i));

endmodule

bind sdbg_line_watch sdbg_line_watch_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid_i),
    .bit_i        (bit_i),
    .id_ok_i      (id_ok_i),
    .swire_mode_o (swire_mode_o),
    .line_reset_o (line_reset_o),
    .id_pend_o    (id_pend_o)
);

// File: tb/tb_sdbg_line_watch.sv
module tb_sdbg_line_watch;
    localparam int          CLK_PERIOD = 10;
    localparam int          RUN        = 50;
    localparam int          HW         = RUN + 16;
    localparam logic [15:0] PAT        = 16'b0111100111100111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_i = 1'b0;
    logic bit_i = 1'b0;
    logic id_ok_i = 1'b0;
    logic swire_mode_o, line_reset_o, id_pend_o;

    int n_chk = 0;
    int n_bad = 0;
    int lr_seen = 0;
    logic [HW-1:0] hist = '0;
    logic exp_mode = 1'b0;
    logic exp_pend = 1'b0;
    logic exp_lr = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdbg_line_watch dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (valid_i),
        .bit_i        (bit_i),
        .id_ok_i      (id_ok_i),
        .swire_mode_o (swire_mode_o),
        .line_reset_o (line_reset_o),
        .id_pend_o    (id_pend_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // one clock: drive on the falling edge, update model, sample after the rising edge
    task automatic step(input logic v, input logic b, input logic ok);
        logic match;
        @(negedge clk);
        valid_i = v;
        bit_i   = b;
        id_ok_i = ok;
        exp_lr  = 1'b0;
        match   = 1'b0;
        if (v) begin
            hist   = {hist[HW-2:0], b};
            exp_lr = (&hist[RUN-1:0]) && !hist[RUN];
            match  = (hist[15:0] == PAT) && (&hist[HW-1:16]);
        end
        if (exp_lr && exp_mode) exp_pend = 1'b1;
        else if (ok) exp_pend = 1'b0;
        if (match) exp_mode = 1'b1;
        @(posedge clk);
        #1;
        if (line_reset_o) lr_seen++;
        chk("R2", "line_reset_o", line_reset_o, exp_lr);
        chk("R4", "swire_mode_o", swire_mode_o, exp_mode);
        chk("R7", "id_pend_o", id_pend_o, exp_pend);
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0);
    endtask

    task automatic word(input logic [15:0] w, input bit gaps);
        for (int i = 15; i >= 0; i--) begin
            if (gaps) step(1'b0, ~w[i], 1'b0);
            step(1'b1, w[i], 1'b0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        valid_i = 1'b0;
        bit_i   = 1'b0;
        id_ok_i = 1'b0;
        hist     = '0;
        exp_mode = 1'b0;
        exp_pend = 1'b0;
        #1;
        chk("R1", "mode in reset", swire_mode_o, 1'b0);
        chk("R1", "pend in reset", id_pend_o, 1'b0);
        chk("R1", "pulse in reset", line_reset_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "mode after reset", swire_mode_o, 1'b0);
        chk("R1", "pulse after reset", line_reset_o, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R2: 49 ones then a zero give no pulse; 50 give exactly one
        lr_seen = 0;
        ones(RUN - 1);
        step(1'b1, 1'b0, 1'b0);
        chk_int("R2", "pulses after 49 ones", lr_seen, 0);
        ones(RUN + 20);
        chk_int("R2", "pulses after 70 ones", lr_seen, 1);

        // R3: invalid cycles (with zero on the line) inside a run
        step(1'b1, 1'b0, 1'b0);
        lr_seen = 0;
        ones(30);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0);
        ones(19);
        chk_int("R3", "no pulse before 50 valid ones", lr_seen, 0);
        ones(1);
        chk_int("R3", "pulse on 50th valid one", lr_seen, 1);

        // R5: 49 ones before the pattern
        do_reset();
        ones(RUN - 1);
        word(PAT, 1'b0);
        chk("R5", "mode after short run", swire_mode_o, 1'b0);

        // R5: every single-bit corruption of the pattern
        for (int k = 0; k < 16; k++) begin
            do_reset();
            ones(RUN + 3);
            word(PAT ^ (16'h1 << k), 1'b0);
            ones(RUN);
            chk("R5", "mode after corrupted pattern", swire_mode_o, 1'b0);
        end

        // R4, R7, R8: full switch sequence
        do_reset();
        id_ok_i = 1'b0;
        ones(RUN + 2);
        chk("R7", "no pend from JTAG line reset", id_pend_o, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk("R8", "ack ignored while clear", id_pend_o, 1'b0);
        word(PAT, 1'b0);
        chk("R4", "mode after pattern", swire_mode_o, 1'b1);
        chk("R7", "pend before trailing ones", id_pend_o, 1'b0);
        ones(RUN);
        chk("R7", "pend after trailing line reset", id_pend_o, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        chk("R8", "pend cleared by ack", id_pend_o, 1'b0);

        // R8: ack on the same edge as a serial-wire line reset
        ones(RUN - 1);
        step(1'b1, 1'b1, 1'b1);
        chk("R8", "line reset wins over ack", id_pend_o, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R8", "ack clears next", id_pend_o, 1'b0);

        // R6: mode holds through zeros, junk and another pattern
        for (int i = 0; i < 20; i++) step(1'b1, i[0], 1'b0);
        ones(RUN);
        word(~PAT, 1'b0);
        chk("R6", "mode sticky", swire_mode_o, 1'b1);

        // R1: asynchronous reset returns to JTAG
        do_reset();
        chk("R1", "mode back to JTAG", swire_mode_o, 1'b0);

        // R3: invalid cycles interleaved in the pattern
        ones(RUN);
        word(PAT, 1'b1);
        chk("R3", "mode with gapped pattern", swire_mode_o, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule